// File: doc/BRIEF.md
# Segmented Streaming Scan Unit

The unit takes a stream of unsigned 32-bit values, one per virtual processor, and turns each into a running combination of the values before it. Four combining operations are available: sum, product, maximum and copy of the first value. Each runs in an inclusive form (the element's own value is part of its result) or an exclusive form (only earlier elements count). A per-element segment-start bit splits the stream into independent subarrays of any length. An activity bit lets an element through untouched and keeps it out of every running value.

Elements enter on a valid/ready stream carrying the value, segment-start, active and last-of-sequence bits. Results leave in arrival order through one output register with its own valid/ready pair. When the final element of a sequence has been handed over, the unit presents the reduction of the whole sequence for one cycle. This is the same operation applied to every active value, with segment starts ignored.

Top module: `scan_unit`

## Requirements
- R1: With op_i=0 (add) and incl_i=1, each active result is the modulo 2^32 sum of the active values from the segment start up to and including that element. The sequence 3,2,6,4,5,11,0,9 gives 3,5,11,15,20,31,31,40.
- R2: With incl_i=0, each active result leaves out the element's own value. The first active element of a segment gets the identity: 0 for add, max and copy, and 1 for multiply. For add, 3,2,6,4,5,11,0,9 gives 0,3,5,11,15,20,31,31.
- R3: With op_i=1 (multiply), results are products modulo 2^32. An active zero makes every later product in its segment 0.
- R4: With op_i=2 (max), the result is the largest unsigned active value seen so far in the segment. 3,2,6,4,5,11,0,9 gives 3,3,6,6,6,11,11,11 inclusive.
- R5: With op_i=3 (copy), every active element of a segment gets the segment's first active value. In exclusive form, the first active element gets 0.
- R6: in_seg_i=1 resets the running value to the identity before the element is combined. The first element after reset, and the first element after an element with in_last_i=1, always starts a segment.
- R7: An element with in_act_i=0 comes out with its input value unchanged and leaves both the segment and the sequence running values as they were.
- R8: red_valid_o is high for exactly one cycle, the cycle after the output handshake of the element that carried in_last_i=1. In that cycle red_data_o holds the selected operation applied to all active values of the sequence, with segment starts ignored.
- R9: While out_valid_o=1 and out_ready_i=0, out_valid_o and out_data_o hold. Results leave in input order, and in_ready_o=1 whenever the output register is empty or is being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 0 add, 1 multiply, 2 max, 3 copy |
| incl_i | input | 1 | 1 inclusive, 0 exclusive |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Unit can accept an element |
| in_data_i | input | W | Element value |
| in_seg_i | input | 1 | Element starts a segment |
| in_act_i | input | 1 | Element is active |
| in_last_i | input | 1 | Element ends the sequence |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_data_o | output | W | Scan result |
| red_valid_o | output | 1 | Sequence reduction valid (one cycle) |
| red_data_o | output | W | Sequence reduction |

## Verification
Several properties are checked on every cycle by the assertions:
- the output holds under backpressure;
- an inactive element passes through;
- an inclusive sum restarts at a segment start;
- an exclusive product starts at one;
- an inclusive maximum is never below the current element;
- an inclusive product after a zero is zero.

Only the bench's scenarios can show the rest. That covers full running values across long segments with inactive holes, wrap-around of products, copy spreading, the exact reduction value and the one-cycle timing of its pulse. It also covers the automatic segment start after a sequence ends. These are checked against a sequence model under random gaps on both handshakes.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_MAX = 2'd2,
    OP_CPY = 2'd3
  } scan_op_e;
endpackage

// File: rtl/scan_alu.sv
module scan_alu
  import scan_pkg::*;
#(
  parameter int W = 32
) (
  input  scan_op_e       op_i,
  input  logic [W-1:0]   acc_i,
  input  logic           emp_i,
  input  logic [W-1:0]   x_i,
  output logic [W-1:0]   ident_o,
  output logic [W-1:0]   y_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    ident_o = (op_i == OP_MUL) ? ONE : '0;
    unique case (op_i)
      OP_ADD:  y_o = acc_i + x_i;
      OP_MUL:  y_o = acc_i * x_i;
      OP_MAX:  y_o = (x_i > acc_i) ? x_i : acc_i;
      default: y_o = emp_i ? x_i : acc_i;
    endcase
  end
endmodule

// File: rtl/scan_lane.sv
module scan_lane
  import scan_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  scan_op_e       op_i,
  input  logic           start_i,
  input  logic           act_i,
  input  logic           en_i,
  input  logic [W-1:0]   x_i,
  output logic [W-1:0]   cur_o,
  output logic [W-1:0]   nxt_o
);
  logic [W-1:0] acc_q, ident;
  logic         emp_q, cur_emp;
  logic [W-1:0] nxt_raw;

  // running value seen by this element, before its own contribution
  assign cur_emp = start_i | emp_q;

  scan_alu #(.W(W)) u_alu (
    .op_i    (op_i),
    .acc_i   (cur_o),
    .emp_i   (cur_emp),
    .x_i     (x_i),
    .ident_o (ident),
    .y_o     (nxt_raw)
  );

  assign cur_o = start_i ? ident : acc_q;
  assign nxt_o = nxt_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      emp_q <= 1'b1;
    end else if (en_i) begin
      acc_q <= act_i ? nxt_raw : cur_o;
      emp_q <= act_i ? 1'b0 : cur_emp;
    end
  end
endmodule

// File: rtl/scan_unit.sv
module scan_unit
  import scan_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     op_i,
  input  logic           incl_i,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [W-1:0]   in_data_i,
  input  logic           in_seg_i,
  input  logic           in_act_i,
  input  logic           in_last_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [W-1:0]   out_data_o,
  output logic           red_valid_o,
  output logic [W-1:0]   red_data_o
);
  localparam int NL = 2;  // lane 0: segment scan, lane 1: whole-sequence reduction
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  scan_op_e     op;
  logic         accept, out_fire;
  logic         first_q;
  logic [NL-1:0] start;
  logic [W-1:0] cur [NL];
  logic [W-1:0] nxt [NL];
  logic [W-1:0] res;

  logic         out_valid_q, out_last_q, red_valid_q;
  logic [W-1:0] out_data_q, red_pend_q, red_data_q;

  assign op         = scan_op_e'(op_i);
  assign in_ready_o = !out_valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;
  assign out_fire   = out_valid_q && out_ready_i;

  assign start[0] = first_q | in_seg_i;
  assign start[1] = first_q;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    scan_lane #(.W(W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .start_i (start[g]),
      .act_i   (in_act_i),
      .en_i    (accept),
      .x_i     (in_data_i),
      .cur_o   (cur[g]),
      .nxt_o   (nxt[g])
    );
  end

  assign res = !in_act_i ? in_data_i : (incl_i ? nxt[0] : cur[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q     <= 1'b1;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
      red_pend_q  <= '0;
      red_data_q  <= '0;
      red_valid_q <= 1'b0;
    end else begin
      red_valid_q <= out_fire && out_last_q;
      // staged so a back-to-back sequence cannot overwrite the pending total
      if (out_fire && out_last_q) red_data_q <= red_pend_q;
      if (accept) begin
        first_q     <= in_last_i;
        out_valid_q <= 1'b1;
        out_data_q  <= res;
        out_last_q  <= in_last_i;
        if (in_last_i) red_pend_q <= in_act_i ? nxt[1] : cur[1];
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign red_valid_o = red_valid_q;
  assign red_data_o  = red_data_q;

  // R7
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !in_act_i |=> out_data_o == $past(in_data_i));
  // R1
  seg_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_act_i && in_seg_i && incl_i && op == OP_ADD |=> out_data_o == $past(in_data_i));
  // R2
  excl_mul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_act_i && in_seg_i && !incl_i && op == OP_MUL |=> out_data_o == ONE);
  // R4
  max_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_act_i && incl_i && op == OP_MAX |=> out_data_o >= $past(in_data_i));
  // R3
  mul_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_act_i && incl_i && op == OP_MUL && in_data_i == '0 |=> out_data_o == '0);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

// File: tb/sim_scan_unit.sv
module sim_scan_unit;
  localparam int W = 32;
  localparam int MAXN = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]   op_i = '0;
  logic         incl_i = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [W-1:0] in_data_i = '0;
  logic         in_seg_i = 1'b0, in_act_i = 1'b0, in_last_i = 1'b0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b0;
  logic [W-1:0] out_data_o;
  logic         red_valid_o;
  logic [W-1:0] red_data_o;

  scan_unit #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .incl_i(incl_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_seg_i(in_seg_i), .in_act_i(in_act_i), .in_last_i(in_last_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .red_valid_o(red_valid_o), .red_data_o(red_data_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] vin [MAXN];
  logic         vseg [MAXN];
  logic         vact [MAXN];
  logic [W-1:0] exp_v [MAXN];
  logic [W-1:0] exp_red;
  int           n;

  function automatic logic [W-1:0] ident(logic [1:0] o);
    return (o == 2'd1) ? 1 : 0;
  endfunction

  function automatic logic [W-1:0] comb(logic [1:0] o, logic [W-1:0] a, bit e, logic [W-1:0] x);
    logic [W-1:0] r;
    case (o)
      2'd0: r = a + x;
      2'd1: r = a * x;
      2'd2: r = (x > a) ? x : a;
      default: r = e ? x : a;
    endcase
    return r;
  endfunction

  task automatic model();
    logic [W-1:0] acc = '0, tot = '0, nv;
    bit emp = 1, temp = 1;
    for (int i = 0; i < n; i++) begin
      if (i == 0 || vseg[i]) begin acc = ident(op_i); emp = 1; end
      if (i == 0) begin tot = ident(op_i); temp = 1; end
      if (vact[i]) begin
        nv = comb(op_i, acc, emp, vin[i]);
        exp_v[i] = incl_i ? nv : acc;
        acc = nv; emp = 0;
        tot = comb(op_i, tot, temp, vin[i]); temp = 0;
      end else begin
        exp_v[i] = vin[i];
      end
    end
    exp_red = tot;
  endtask

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_seq(string tag);
    int ii = 0, oi = 0, cyc = 0;
    bit red_seen = 0, red_due = 0, hold = 0;
    logic [W-1:0] hv = '0;
    model();
    while (!(oi == n && red_seen) && cyc < 4000) begin
      @(negedge clk);
      if (ii < n && ($urandom % 4 != 0)) begin
        in_valid_i = 1'b1; in_data_i = vin[ii]; in_seg_i = vseg[ii];
        in_act_i = vact[ii]; in_last_i = (ii == n - 1);
      end else begin
        in_valid_i = 1'b0;
      end
      out_ready_i = ($urandom % 4 != 0);
      #1;
      if (hold) begin
        check("R9 hold valid", W'(out_valid_o), 1);
        check("R9 hold data", out_data_o, hv);
      end
      if (red_due) begin
        check("R8 reduction pulse", W'(red_valid_o), 1);
        check("R8 reduction value", red_data_o, exp_red);
        red_seen = 1; red_due = 0;
      end else begin
        check("R8 no stray pulse", W'(red_valid_o), 0);
      end
      hold = 0;
      if (out_valid_o && out_ready_i) begin
        check(vact[oi] ? tag : "R7 inactive passthrough", out_data_o, exp_v[oi]);
        if (oi == n - 1) red_due = 1;
        oi++;
      end else if (out_valid_o) begin
        hold = 1; hv = out_data_o;
      end
      if (in_valid_i && in_ready_o) ii++;
      cyc++;
    end
    if (!(oi == n && red_seen)) check({tag, " sequence incomplete"}, W'(oi), W'(n));
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ex [8] = '{3, 2, 6, 4, 5, 11, 0, 9};
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", W'(out_valid_o), 0);
    check("R8 reset red_valid", W'(red_valid_o), 0);
    check("R9 reset in_ready", W'(in_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);

    // worked example in every operation and form
    for (int o = 0; o < 4; o++) begin
      for (int inc = 0; inc < 2; inc++) begin
        string tag;
        op_i = 2'(o); incl_i = inc[0];
        n = 8;
        for (int i = 0; i < 8; i++) begin vin[i] = ex[i]; vseg[i] = 0; vact[i] = 1; end
        case (o)
          0: tag = inc ? "R1 add inclusive" : "R2 add exclusive";
          1: tag = "R3 multiply";
          2: tag = "R4 max";
          default: tag = "R5 copy";
        endcase
        run_seq(tag);
      end
    end

    // product wrap-around, zero forcing
    op_i = 2'd1; incl_i = 1'b1; n = 6;
    for (int i = 0; i < 6; i++) begin vin[i] = 32'h0001_0003; vseg[i] = 0; vact[i] = 1; end
    vin[3] = 0; vseg[4] = 1;
    run_seq("R3 product wrap");

    // segmented random sweep with inactive holes
    for (int r = 0; r < 64; r++) begin
      op_i = 2'(r % 4); incl_i = r[2];
      n = 1 + ($urandom % MAXN);
      for (int i = 0; i < n; i++) begin
        vin[i]  = ($urandom % 8 == 0) ? $urandom : W'($urandom % 16);
        vseg[i] = ($urandom % 4 == 0);
        vact[i] = ($urandom % 5 != 0);
      end
      run_seq(vseg[0] ? "R6 segmented" : "R6 segmented, implicit start");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule